// File: doc/BRIEF.md
# Adaptive Transient Clipper for a Real Sample Stream

This block sits in front of a channelising filter bank and removes short, strong bursts of interference from a stream of signed time-domain samples. It tracks the stream's mean and its variance with two exponential averagers. For each incoming sample it compares the squared distance from the mean with a programmable multiple of the tracked variance. A sample that lies too far out is replaced by the current mean and flagged. Any other sample is forwarded unchanged.

The averaging window is chosen by a 3-bit select in powers of two, from 2 to 128 samples. A 16-bit threshold coefficient scales the variance. A coefficient of zero turns the clipper into a plain delay line. A clipped sample never feeds the variance average, so a long burst cannot raise its own detection limit. The mean is updated with the value that was actually sent out. After reset both averages are zero, and clipping stays off until the window has been filled once.

Top module: `rfi_transient_clipper`

## Requirements
- R1: Every sample accepted with `in_valid` high appears on the output with `out_valid` high exactly two clock edges later. `out_valid` is low in every other cycle.
- R2: When `out_clip` is low, `out_data` equals the input sample from two edges earlier, bit for bit.
- R3: The mean M and the variance V are fixed-point values with 4 fractional bits. With x the current sample, the sample is clipped when (16·x − M)² > `thresh` · V · 16, the squared deviation is in units of 1/256, and both sides are compared as exact integers.
- R4: A clipped sample is output as floor(M / 16), that is, the mean truncated toward minus infinity, and `out_clip` is high with it.
- R5: With `thresh` = 0, no sample is ever clipped and every sample passes unchanged.
- R6: A `tc_sel` value s gives the shift k = s + 1 for s = 0 to 6, and k = 7 for s = 7. Each update is A ← A + floor((T − A) / 2^k). For the mean, T = 16·y, where y is the output value. For the variance, T = floor((16·x − M)² / 16).
- R7: A clipped sample leaves V unchanged. M is still updated, using the replacement value.
- R8: After reset, M and V are zero. A sample is eligible for clipping only once at least 2^k earlier samples have been accepted since reset.
- R9: While reset is asserted and after it, until the first output, `out_valid`, `out_data` and `out_clip` are zero.
- R10: `out_clip` is high only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 9 | Signed input sample |
| tc_sel | input | 3 | Averaging window select (k = s + 1, saturating at 7) |
| thresh | input | 16 | Unsigned threshold coefficient; 0 disables clipping |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 9 | Signed output sample, original or replacement |
| out_clip | output | 1 | High when the output sample is a replacement |

## Verification
The main function is exercised with three kinds of input. Low-level alternating noise with isolated spikes of either sign shows whether the variance-scaled limit separates a genuine outlier from ordinary noise. A run of consecutive large spikes after a quiet stretch shows whether clipped samples are kept out of the variance, because every spike must still be caught. Spikes sent during the first 2^k samples, or with a zero coefficient, must pass through untouched, which separates the warm-up inhibit and the disable setting from the detector itself. A long run at the widest window setting compares the saturating select against an independent arithmetic model of the averages.

// File: rtl/rfi_clip_pkg.sv
package rfi_clip_pkg;
  localparam int TC_SEL_W = 3;
  localparam int K_W      = 3;
  localparam int K_MAX    = 7;

  // window select to shift amount: s+1, saturating at K_MAX
  function automatic logic [K_W-1:0] k_of_sel(input logic [TC_SEL_W-1:0] sel);
    if (int'(sel) >= K_MAX - 1)
      return K_W'(K_MAX);
    else
      return K_W'(int'(sel) + 1);
  endfunction
endpackage

// File: rtl/rfi_ewma.sv
module rfi_ewma #(
  parameter int W   = 13,
  parameter int K_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [K_W-1:0]      k,
  input  logic signed [W-1:0] target,
  output logic signed [W-1:0] avg_q
);
  logic signed [W:0]   diff;
  logic signed [W-1:0] step;

  assign diff = (W+1)'(target) - (W+1)'(avg_q);
  assign step = W'(diff >>> k);

  always_ff @(posedge clk) begin
    if (rst)
      avg_q <= '0;
    else if (en)
      avg_q <= avg_q + step;
  end
endmodule

// File: rtl/rfi_warmup.sv
module rfi_warmup #(
  parameter int CW  = 8,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [K_W-1:0] k,
  output logic           armed
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   limit;

  assign limit = (CW+1)'(1) << k;
  assign armed = {1'b0, cnt_q} >= limit;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (step && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfi_clip_detect.sv
module rfi_clip_detect #(
  parameter int DW = 9,
  parameter int FW = 4,
  parameter int BW = 16,
  parameter int MW = DW + FW,
  parameter int SQW = 2 * (MW + 1),
  parameter int VW = SQW - FW
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [MW-1:0] mean,
  input  logic [VW:0]          var_avg,
  input  logic [BW-1:0]        thresh,
  input  logic                 armed,
  output logic                 clip,
  output logic [VW-1:0]        dev_sq_scaled,
  output logic signed [DW-1:0] repl
);
  localparam int PRW = BW + VW + 1;
  localparam int PW  = PRW + FW;

  logic signed [MW:0] x_fp, mean_e, dev;
  logic [MW:0]        mag;
  logic [SQW-1:0]     sq;
  logic [PRW-1:0]     prod;
  logic [PW-1:0]      lhs, rhs;

  assign x_fp   = (MW+1)'(x) <<< FW;
  assign mean_e = (MW+1)'(mean);
  assign dev    = x_fp - mean_e;
  assign mag    = dev[MW] ? (MW+1)'(-dev) : (MW+1)'(dev);
  assign sq     = SQW'(mag) * SQW'(mag);

  assign dev_sq_scaled = sq[SQW-1:FW];

  assign prod = PRW'(thresh) * PRW'(var_avg);
  assign lhs  = PW'(sq);
  assign rhs  = {prod, {FW{1'b0}}};

  assign clip = armed && (thresh != '0) && (lhs > rhs);
  assign repl = mean[MW-1:FW];
endmodule

// File: rtl/rfi_transient_clipper.sv
module rfi_transient_clipper #(
  parameter int DW = 9,
  parameter int FW = 4,
  parameter int BW = 16,
  parameter int CW = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic signed [DW-1:0]           in_data,
  input  logic [rfi_clip_pkg::TC_SEL_W-1:0] tc_sel,
  input  logic [BW-1:0]                  thresh,
  output logic                           out_valid,
  output logic signed [DW-1:0]           out_data,
  output logic                           out_clip
);
  import rfi_clip_pkg::*;

  localparam int MW  = DW + FW;
  localparam int SQW = 2 * (MW + 1);
  localparam int VW  = SQW - FW;

  logic                 s1_v;
  logic signed [DW-1:0] s1_x;
  logic [K_W-1:0]       k;
  logic                 armed, clip;
  logic signed [MW-1:0] mean_q, mean_tgt;
  logic signed [VW:0]   var_q, var_tgt;
  logic [VW-1:0]        dsq;
  logic signed [DW-1:0] repl, y;

  assign k = k_of_sel(tc_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_x <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid)
        s1_x <= in_data;
    end
  end

  rfi_warmup #(.CW(CW), .K_W(K_W)) i_warmup (
    .clk(clk), .rst(rst), .step(s1_v), .k(k), .armed(armed)
  );

  rfi_clip_detect #(.DW(DW), .FW(FW), .BW(BW)) i_detect (
    .x(s1_x), .mean(mean_q), .var_avg(var_q), .thresh(thresh),
    .armed(armed), .clip(clip), .dev_sq_scaled(dsq), .repl(repl)
  );

  assign y        = clip ? repl : s1_x;
  assign mean_tgt = MW'(y) <<< FW;
  assign var_tgt  = {1'b0, dsq};

  rfi_ewma #(.W(MW), .K_W(K_W)) i_mean (
    .clk(clk), .rst(rst), .en(s1_v), .k(k), .target(mean_tgt), .avg_q(mean_q)
  );

  rfi_ewma #(.W(VW+1), .K_W(K_W)) i_var (
    .clk(clk), .rst(rst), .en(s1_v && !clip), .k(k), .target(var_tgt), .avg_q(var_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_clip  <= 1'b0;
    end else begin
      out_valid <= s1_v;
      out_clip  <= s1_v && clip;
      if (s1_v)
        out_data <= y;
    end
  end
endmodule

// File: rtl/rfi_clipper_chk.sv
module rfi_clipper_chk #(
  parameter int DW = 9,
  parameter int BW = 16,
  parameter int CW = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              in_valid,
  input logic signed [DW-1:0]              in_data,
  input logic [rfi_clip_pkg::TC_SEL_W-1:0] tc_sel,
  input logic [BW-1:0]                     thresh,
  input logic                              out_valid,
  input logic signed [DW-1:0]              out_data,
  input logic                              out_clip
);
  import rfi_clip_pkg::*;

  localparam logic [CW-1:0] N_MAX = '1;

  logic [CW-1:0]           n_out;
  logic [TC_SEL_W-1:0]     tc_q;
  logic [BW-1:0]           thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_out <= '0;
      tc_q  <= '0;
      thr_q <= '0;
    end else begin
      tc_q  <= tc_sel;
      thr_q <= thresh;
      if (out_valid && n_out != N_MAX)
        n_out <= n_out + 1'b1;
    end
  end

  // R1
  a_r1_valid_two_edges: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  // R2
  a_r2_pass_unchanged: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_clip) |-> out_data == $past(in_data, 2));
  // R5
  a_r5_zero_disables: assert property (@(posedge clk) disable iff (rst)
    (thr_q == '0) |-> !out_clip);
  // R8
  a_r8_warmup_inhibit: assert property (@(posedge clk) disable iff (rst)
    out_clip |-> ({1'b0, n_out} >= ((CW+1)'(1) << k_of_sel(tc_q))));
  // R10
  a_r10_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_clip |-> out_valid);
endmodule

bind rfi_transient_clipper rfi_clipper_chk #(.DW(DW), .BW(BW), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .tc_sel(tc_sel), .thresh(thresh), .out_valid(out_valid),
  .out_data(out_data), .out_clip(out_clip)
);

// File: tb/test_rfi_transient_clipper.sv
module test_rfi_transient_clipper;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [8:0] in_data = '0;
  logic [2:0]        tc_sel = '0;
  logic [15:0]       thresh = '0;
  logic              out_valid;
  logic signed [8:0] out_data;
  logic              out_clip;

  int checks = 0;
  int errors = 0;
  longint m_mean, m_var;
  int m_cnt;

  always #10 clk = ~clk;

  rfi_transient_clipper i_rfi_transient_clipper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tc_sel(tc_sel), .thresh(thresh), .out_valid(out_valid),
    .out_data(out_data), .out_clip(out_clip)
  );

  localparam int NV = 20;
  localparam int VSEL [NV] = '{0,0,0,0,0,0,0,0,0,0, 2,2,2,2,2,2,2,2,2,2};
  localparam int VTHR [NV] = '{8,8,8,8,8,8,8,8,8,8, 3,3,3,3,3,3,0,0,3,3};
  localparam int VX   [NV] = '{5,-5,6,-4,5,-6,180,3,-200,-3,
                               20,-20,30,-25,100,-90,255,-256,10,-250};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mean = 0; m_var = 0; m_cnt = 0;
  endtask

  // arithmetic model taken from R3, R4, R6, R7, R8
  task automatic model(input int x, input int sel, input int thr, output int ey, output bit ec);
    int k;
    longint dev, dsq, yv;
    k   = (sel >= 6) ? 7 : sel + 1;
    dev = longint'(x) * 16 - m_mean;
    dsq = dev * dev;
    ec  = (thr != 0) && (m_cnt >= (1 << k)) && (dsq > longint'(thr) * m_var * 16);
    yv  = ec ? (m_mean >>> 4) : longint'(x);
    m_mean = m_mean + ((yv * 16 - m_mean) >>> k);
    if (!ec) m_var = m_var + (((dsq >>> 4) - m_var) >>> k);
    if (m_cnt < 255) m_cnt++;
    ey = int'(yv);
  endtask

  task automatic send(input int x, output int y, output bit c);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 9'(x);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R1 idle between", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1 valid after two edges", int'(out_valid), 1);
    y = int'(out_data);
    c = out_clip;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    check(out_data == '0, "R9 data in reset", int'(out_data), 0);
    check(out_clip == 1'b0, "R9 flag in reset", int'(out_clip), 0);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic send_model(input int x, input string req);
    int y, ey;
    bit c, ec;
    model(x, int'(tc_sel), int'(thresh), ey, ec);
    send(x, y, c);
    check(y == ey, req, y, ey);
    check(c == ec, req, int'(c), int'(ec));
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int y;
    bit c;
    int nclip;
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0 && out_clip == 1'b0, "R9 after reset", int'(out_valid), 0);

    // table walk: R3 R4 R6 R7 against the model
    for (int i = 0; i < NV; i++) begin
      tc_sel = 3'(VSEL[i]);
      thresh = 16'(VTHR[i]);
      send_model(VX[i], "R3 table");
    end

    // R8: spikes during warm-up at k=7 must not clip
    do_reset();
    tc_sel = 3'd6;
    thresh = 16'd1;
    for (int i = 0; i < 128; i++) begin
      int x = (i % 2 == 0) ? 255 : -256;
      if (i % 3 == 0) x = 0;
      send(x, y, c);
      check(c == 1'b0 && y == x, "R8 warm-up pass", y, x);
    end

    // R7: burst after quiet noise, every spike must be caught
    do_reset();
    tc_sel = 3'd0;
    thresh = 16'd8;
    for (int i = 0; i < 8; i++) send_model((i % 2 == 0) ? 4 : -4, "R6 quiet");
    nclip = 0;
    for (int i = 0; i < 6; i++) begin
      int ey;
      bit ec;
      model(250, 0, 8, ey, ec);
      send(250, y, c);
      check(c == 1'b1, "R7 burst flagged", int'(c), 1);
      check(y == ey, "R4 replacement", y, ey);
      if (c) nclip++;
    end
    check(nclip == 6, "R7 whole burst", nclip, 6);

    // R5: zero coefficient passes everything
    thresh = 16'd0;
    for (int i = 0; i < 6; i++) begin
      int x = (i % 2 == 0) ? -256 : 255;
      send(x, y, c);
      check(c == 1'b0 && y == x, "R5 disabled", y, x);
      model(x, 0, 0, y, c);
    end

    // R6: select 7 saturates at k=7, compared with model
    do_reset();
    tc_sel = 3'd7;
    thresh = 16'd2;
    for (int i = 0; i < 140; i++) begin
      int x = (i % 4) * 3 - 4;
      if (i == 130 || i == 137) x = -240;
      send_model(x, "R6 select 7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule